// File: doc/BRIEF.md
# Pulse Discriminator with Sample Packer

This block sits on one fast photodetector channel that delivers one digitized sample per strobe (nominally 64 MHz). It forms a post-minus-pre difference, the current sample minus the sample that arrived a programmable number of strobes earlier, and compares it against a per-channel signed threshold. A sample whose difference is strictly above the threshold is a firing. Only samples near a firing are written into a 33-bit wide FIFO. The rest of the stream is discarded before it reaches any storage, so the memory behind the FIFO sees a small fraction of the raw rate.

Each stored packet opens with a header word that carries the frame number and the sample number of the firing that opened it. Data words follow, each holding two samples. The window of kept samples reaches a programmable count before a firing and a programmable count after it. Windows that overlap or touch merge into a single packet. A packet is admitted only if the FIFO can take a header plus the largest allowed body. If it cannot, the whole packet is discarded and a saturating counter is incremented. Separately, every run of consecutive firings is measured: the largest difference seen in the run and the run length are reported to the trigger logic once the run ends.

The packer is a three-state machine:
- `PK_IDLE`: no window is open.
- `PK_STORE`: a packet is being written.
- `PK_SKIP`: the rest of the current window is being thrown away.

Its transitions are:
- IDLE→STORE: a firing arrives and there is room.
- IDLE→SKIP: a firing arrives and there is no room.
- STORE→SKIP: the body has reached its word cap.
- STORE→IDLE: the window closes.
- SKIP→IDLE: the window closes.

The run meter has two states, `M_QUIET` and `M_RUN`. Its transitions are:
- QUIET→RUN: on a firing.
- RUN→QUIET: on the first non-firing sample, which also issues the report.

Top module: `pdisc_top`

## Requirements
- R1: After reset the FIFO is empty (`rd_empty`=1), `pulse_valid`=0 and `ovf_cnt`=0. Sample history starts at zero, so before `cfg_gap` samples have arrived the older operand of the difference is 0.
- R2: A sample j fires when s(j) − s(j−n) > `cfg_thr`, with n=`cfg_gap` and both values treated as signed. A difference exactly equal to the threshold does not fire.
- R3: The distance n is taken from `cfg_gap` over the range 1..HIST. The same data can fire at one distance and stay quiet at another.
- R4: Sample k is stored if and only if some sample in [k−`cfg_post`, k+`cfg_pre`] fired. Samples with a negative index read as 0. A contiguous stretch of stored samples forms a single packet, so overlapping windows merge.
- R5: A packet starts with a header word. Bit 32 is 1, bits 31:16 hold `frame_num` and bits 15:0 hold `sample_num`, both as driven with the firing sample that opened the packet.
- R6: Data words have bit 32 = 0. The earlier sample sits in bits 15:0 and the later one in bits 31:16. If the packet has an odd number of samples, the last word carries 0 in bits 31:16.
- R7: Samples outside every window never appear in the FIFO.
- R8: A packet opens only if the FIFO occupancy is at most DEPTH−1−MAXW. Otherwise the whole window is discarded and `ovf_cnt` increases by exactly one, saturating.
- R9: A packet body is capped at MAXW data words. Once the cap is reached, the remaining samples of that window are discarded and no new packet opens until the window has closed.
- R10: For each run of consecutive firing samples, `pulse_valid` pulses for one cycle after the first non-firing sample is accepted. `pulse_peak` is the largest difference in the run and `pulse_width` is its length.
- R11: Cycles with `smp_valid`=0 leave every output stream unchanged. Results depend only on the sequence of accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp | input | SW | Sample value, unsigned |
| frame_num | input | SW | Frame number accompanying the sample |
| sample_num | input | SW | Sample number accompanying the sample |
| cfg_gap | input | clog2(HIST+1) | Difference distance n |
| cfg_thr | input | SW+1 | Signed firing threshold |
| cfg_pre | input | clog2(HIST+1) | Samples kept before a firing |
| cfg_post | input | PW | Samples kept after a firing |
| rd_en | input | 1 | FIFO pop |
| rd_data | output | 2*SW+1 | FIFO head word (show-ahead) |
| rd_empty | output | 1 | FIFO empty |
| pulse_valid | output | 1 | Run report strobe |
| pulse_peak | output | SW+1 | Largest signed difference in the run |
| pulse_width | output | WW | Run length in samples |
| ovf_cnt | output | OW | Count of dropped packets |

## Verification
The hardest conditions to reach from the ports are packet drops and body truncation. A drop needs the FIFO filled to within one maximum packet of full while no reads take place. A dedicated phase therefore fires more than a hundred closely spaced pulses with wide windows and reads nothing until the end, which forces the room check to fail repeatedly. Truncation needs a window longer than 2·MAXW samples. A steep ramp with gap 1 keeps every sample above threshold for longer than that span. Random phases vary the gap, threshold and window settings and insert idle strobes, and a bench model derives the expected word stream and run reports directly from the window definition.

// File: rtl/pdisc_pkg.sv
package pdisc_pkg;
    typedef enum logic [1:0] {
        PK_IDLE  = 2'd0,
        PK_STORE = 2'd1,
        PK_SKIP  = 2'd2
    } pk_state_e;

    typedef enum logic {
        M_QUIET = 1'b0,
        M_RUN   = 1'b1
    } run_state_e;
endpackage

// File: rtl/pdisc_front.sv
module pdisc_front #(
    parameter int SW   = 16,
    parameter int HIST = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [SW-1:0]                smp,
    input  logic [$clog2(HIST+1)-1:0]    cfg_gap,
    input  logic [$clog2(HIST+1)-1:0]    cfg_pre,
    input  logic signed [SW:0]           cfg_thr,
    output logic                         over,
    output logic signed [SW:0]           diff,
    output logic [SW-1:0]                dly_smp
);
    localparam int IW = $clog2(HIST);
    localparam int GW = $clog2(HIST+1);

    logic [SW-1:0] hist [HIST];
    logic [SW-1:0] older;

    // history line: hist[0] is the previous accepted sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST; i++) hist[i] <= '0;
        end else if (smp_valid) begin
            hist[0] <= smp;
            for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
        end
    end

    function automatic logic [IW-1:0] tap(input logic [GW-1:0] d);
        if (d == '0)        return '0;
        else if (d > HIST)  return IW'(HIST-1);
        else                return IW'(d - 1'b1);
    endfunction

    always_comb begin
        older   = hist[tap(cfg_gap)];
        diff    = $signed({1'b0, smp}) - $signed({1'b0, older});
        over    = (diff > cfg_thr);
        dly_smp = (cfg_pre == '0) ? smp : hist[tap(cfg_pre)];
    end
endmodule

// File: rtl/pdisc_meter.sv
module pdisc_meter
    import pdisc_pkg::*;
#(
    parameter int SW = 16,
    parameter int WW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic                 over,
    input  logic signed [SW:0]   diff,
    output logic                 pulse_valid,
    output logic signed [SW:0]   pulse_peak,
    output logic [WW-1:0]        pulse_width
);
    run_state_e        rs_q;
    logic signed [SW:0] peak_q;
    logic [WW-1:0]      width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q        <= M_QUIET;
            peak_q      <= '0;
            width_q     <= '0;
            pulse_valid <= 1'b0;
            pulse_peak  <= '0;
            pulse_width <= '0;
        end else begin
            pulse_valid <= 1'b0;
            if (smp_valid) begin
                unique case (rs_q)
                    M_QUIET: begin
                        if (over) begin
                            rs_q    <= M_RUN;
                            peak_q  <= diff;
                            width_q <= WW'(1);
                        end
                    end
                    M_RUN: begin
                        if (over) begin
                            if (diff > peak_q) peak_q <= diff;
                            if (width_q != '1) width_q <= width_q + 1'b1;
                        end else begin
                            rs_q        <= M_QUIET;
                            pulse_valid <= 1'b1;
                            pulse_peak  <= peak_q;
                            pulse_width <= width_q;
                        end
                    end
                    default: rs_q <= M_QUIET;
                endcase
            end
        end
    end

    // R10: a report always describes a non-empty run
    a_r10_width_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_valid |-> (pulse_width != '0));
    // R10: a run needs a firing and a quiet sample, so reports never come back to back
    a_r10_no_double_report: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_valid |=> !pulse_valid);
endmodule

// File: rtl/pdisc_fifo.sv
module pdisc_fifo #(
    parameter int DW = 33,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty,
    output logic [AW:0]   count
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wptr, rptr;
    logic          full;

    assign count    = wptr - rptr;
    assign full     = (count == (AW+1)'(DEPTH));
    assign rd_empty = (count == '0);
    assign rd_data  = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wptr[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en && !full)    wptr <= wptr + 1'b1;
            if (rd_en && !rd_empty) rptr <= rptr + 1'b1;
        end
    end

    // R8: the packer's room check must keep writes away from a full FIFO
    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
endmodule

// File: rtl/pdisc_pack.sv
module pdisc_pack
    import pdisc_pkg::*;
#(
    parameter int SW   = 16,
    parameter int GW   = 5,
    parameter int PW   = 8,
    parameter int MAXW = 32,
    parameter int AW   = 10,
    parameter int OW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic            over,
    input  logic [SW-1:0]   dly_smp,
    input  logic [GW-1:0]   cfg_pre,
    input  logic [PW-1:0]   cfg_post,
    input  logic [SW-1:0]   frame_num,
    input  logic [SW-1:0]   sample_num,
    input  logic [AW:0]     fifo_cnt,
    output logic            wr_en,
    output logic [2*SW:0]   wr_data,
    output logic [OW-1:0]   ovf_cnt
);
    localparam int CW    = ((GW > PW) ? GW : PW) + 1;
    localparam int NW    = $clog2(MAXW + 1);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] ROOM_LIM = (AW+1)'(DEPTH - 1 - MAXW);

    pk_state_e     state_q, state_d;
    logic [CW-1:0] win_q;
    logic [SW-1:0] half_q;
    logic          half_v_q;
    logic [NW-1:0] nw_q;
    logic          keep;
    logic          ld_half, clr_half, inc_nw, clr_nw, bump_ovf;

    assign keep = over || (win_q != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PK_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        wr_en    = 1'b0;
        wr_data  = '0;
        ld_half  = 1'b0;
        clr_half = 1'b0;
        inc_nw   = 1'b0;
        clr_nw   = 1'b0;
        bump_ovf = 1'b0;
        if (smp_valid) begin
            unique case (state_q)
                PK_IDLE: begin
                    if (keep) begin
                        if (fifo_cnt <= ROOM_LIM) begin
                            state_d = PK_STORE;
                            wr_en   = 1'b1;
                            wr_data = {1'b1, frame_num, sample_num};
                            ld_half = 1'b1;
                            clr_nw  = 1'b1;
                        end else begin
                            state_d  = PK_SKIP;
                            bump_ovf = 1'b1;
                        end
                    end
                end
                PK_STORE: begin
                    if (!keep) begin
                        state_d  = PK_IDLE;
                        clr_half = 1'b1;
                        if (half_v_q) begin
                            wr_en   = 1'b1;
                            wr_data = {1'b0, {SW{1'b0}}, half_q};
                        end
                    end else if (half_v_q) begin
                        wr_en    = 1'b1;
                        wr_data  = {1'b0, dly_smp, half_q};
                        clr_half = 1'b1;
                        inc_nw   = 1'b1;
                        if (nw_q == NW'(MAXW - 1)) state_d = PK_SKIP;
                    end else begin
                        ld_half = 1'b1;
                    end
                end
                PK_SKIP: begin
                    if (!keep) state_d = PK_IDLE;
                end
                default: state_d = PK_IDLE;
            endcase
        end
    end

    // window counter, half word, body count, drop counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q    <= '0;
            half_q   <= '0;
            half_v_q <= 1'b0;
            nw_q     <= '0;
            ovf_cnt  <= '0;
        end else begin
            if (smp_valid) begin
                if (over)               win_q <= CW'(cfg_pre) + CW'(cfg_post);
                else if (win_q != '0)   win_q <= win_q - 1'b1;
            end
            if (ld_half) begin
                half_q   <= dly_smp;
                half_v_q <= 1'b1;
            end else if (clr_half) begin
                half_v_q <= 1'b0;
            end
            if (clr_nw)      nw_q <= '0;
            else if (inc_nw) nw_q <= nw_q + 1'b1;
            if (bump_ovf && ovf_cnt != '1) ovf_cnt <= ovf_cnt + 1'b1;
        end
    end

    // R4: no window can be open while the packer idles
    a_r4_idle_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PK_IDLE) |-> (win_q == '0));
    // R5: a header word is always followed by an open packet
    a_r5_header_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2*SW]) |=> (state_q == PK_STORE));
    // R9: body never exceeds its cap
    a_r9_body_cap: assert property (@(posedge clk) disable iff (!rst_n)
        nw_q <= NW'(MAXW));
    // R8: drop counter moves by one at a time
    a_r8_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt != $past(ovf_cnt)) |-> (ovf_cnt == $past(ovf_cnt) + 1'b1));
endmodule

// File: rtl/pdisc_top.sv
module pdisc_top #(
    parameter int SW   = 16,
    parameter int HIST = 16,
    parameter int PW   = 8,
    parameter int MAXW = 32,
    parameter int AW   = 10,
    parameter int OW   = 16,
    parameter int WW   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [SW-1:0]              smp,
    input  logic [SW-1:0]              frame_num,
    input  logic [SW-1:0]              sample_num,
    input  logic [$clog2(HIST+1)-1:0]  cfg_gap,
    input  logic signed [SW:0]         cfg_thr,
    input  logic [$clog2(HIST+1)-1:0]  cfg_pre,
    input  logic [PW-1:0]              cfg_post,
    input  logic                       rd_en,
    output logic [2*SW:0]              rd_data,
    output logic                       rd_empty,
    output logic                       pulse_valid,
    output logic signed [SW:0]         pulse_peak,
    output logic [WW-1:0]              pulse_width,
    output logic [OW-1:0]              ovf_cnt
);
    localparam int GW = $clog2(HIST+1);

    logic                over;
    logic signed [SW:0]  diff;
    logic [SW-1:0]       dly_smp;
    logic                wr_en;
    logic [2*SW:0]       wr_data;
    logic [AW:0]         fifo_cnt;

    pdisc_front #(.SW(SW), .HIST(HIST)) front_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp),
        .cfg_gap(cfg_gap), .cfg_pre(cfg_pre), .cfg_thr(cfg_thr),
        .over(over), .diff(diff), .dly_smp(dly_smp)
    );

    pdisc_meter #(.SW(SW), .WW(WW)) meter_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .over(over), .diff(diff),
        .pulse_valid(pulse_valid), .pulse_peak(pulse_peak), .pulse_width(pulse_width)
    );

    pdisc_pack #(.SW(SW), .GW(GW), .PW(PW), .MAXW(MAXW), .AW(AW), .OW(OW)) pack_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .over(over), .dly_smp(dly_smp),
        .cfg_pre(cfg_pre), .cfg_post(cfg_post), .frame_num(frame_num),
        .sample_num(sample_num), .fifo_cnt(fifo_cnt),
        .wr_en(wr_en), .wr_data(wr_data), .ovf_cnt(ovf_cnt)
    );

    pdisc_fifo #(.DW(2*SW+1), .AW(AW)) fifo_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .count(fifo_cnt)
    );
endmodule

// File: tb/pdisc_top_tb_top.sv
`timescale 1ns/1ps
module pdisc_top_tb_top;
    localparam int SW = 16, HIST = 16, PW = 8, MAXW = 32, AW = 10, OW = 16, WW = 16;
    localparam int DEPTH = 1 << AW;
    localparam int GW = $clog2(HIST+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [SW-1:0] smp = '0, frame_num = '0, sample_num = '0;
    logic [GW-1:0] cfg_gap = GW'(1), cfg_pre = '0;
    logic signed [SW:0] cfg_thr = '0;
    logic [PW-1:0] cfg_post = '0;
    logic rd_en = 1'b0;
    logic [2*SW:0] rd_data;
    logic rd_empty, pulse_valid;
    logic signed [SW:0] pulse_peak;
    logic [WW-1:0] pulse_width;
    logic [OW-1:0] ovf_cnt;

    always #2.5 clk = ~clk;

    pdisc_top #(.SW(SW), .HIST(HIST), .PW(PW), .MAXW(MAXW), .AW(AW), .OW(OW), .WW(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp), .frame_num(frame_num),
        .sample_num(sample_num), .cfg_gap(cfg_gap), .cfg_thr(cfg_thr), .cfg_pre(cfg_pre),
        .cfg_post(cfg_post), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
        .pulse_valid(pulse_valid), .pulse_peak(pulse_peak), .pulse_width(pulse_width),
        .ovf_cnt(ovf_cnt)
    );

    int total = 0, bad = 0;
    int s_arr[$];
    logic [2*SW:0] exp_w[$];
    int exp_pk[$], exp_pw[$], got_pk[$], got_pw[$];
    int exp_ovf;
    int g_gap, g_thr, g_pre, g_post, g_frm;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && pulse_valid) begin
            got_pk.push_back(int'(pulse_peak));
            got_pw.push_back(int'(pulse_width));
        end
    end

    function automatic int mdiff(int j);
        return s_arr[j] - ((j >= g_gap) ? s_arr[j - g_gap] : 0);
    endfunction

    // expected FIFO words, run reports and drop count from the requirement definitions
    task automatic build_expect();
        int n = s_arr.size();
        bit ov[] = new[n];
        bit kp[] = new[n];
        int inrun = 0, pk = 0, wd = 0;
        int fill = 0, mode = 0, half = -1, nw = 0;
        exp_w.delete(); exp_pk.delete(); exp_pw.delete(); exp_ovf = 0;
        for (int j = 0; j < n; j++) ov[j] = (mdiff(j) > g_thr);
        for (int j = 0; j < n; j++) begin
            if (ov[j]) begin
                if (!inrun) begin inrun = 1; pk = mdiff(j); wd = 1; end
                else begin if (mdiff(j) > pk) pk = mdiff(j); wd++; end
            end else if (inrun) begin
                inrun = 0; exp_pk.push_back(pk); exp_pw.push_back(wd);
            end
        end
        for (int j = 0; j < n; j++) begin
            kp[j] = 0;
            for (int t = j - g_pre - g_post; t <= j; t++)
                if (t >= 0 && ov[t]) kp[j] = 1;
        end
        for (int j = 0; j < n; j++) begin
            int v = (j - g_pre >= 0) ? s_arr[j - g_pre] : 0;
            if (mode == 0) begin
                if (kp[j]) begin
                    if (fill + 1 + MAXW <= DEPTH) begin
                        exp_w.push_back({1'b1, SW'(g_frm), SW'(j)});
                        fill++; half = v; nw = 0; mode = 1;
                    end else begin
                        exp_ovf++; mode = 2;
                    end
                end
            end else if (mode == 1) begin
                if (!kp[j]) begin
                    if (half >= 0) begin exp_w.push_back({1'b0, SW'(0), SW'(half)}); fill++; end
                    half = -1; mode = 0;
                end else if (half >= 0) begin
                    exp_w.push_back({1'b0, SW'(v), SW'(half)});
                    fill++; nw++; half = -1;
                    if (nw == MAXW) mode = 2;
                end else half = v;
            end else if (!kp[j]) mode = 0;
        end
    endtask

    task automatic add_flat(int n, int base, int noise);
        for (int i = 0; i < n; i++) s_arr.push_back(base + int'($urandom_range(noise)));
    endtask

    task automatic add_pulse(int amp, int base);
        s_arr.push_back(base + amp);
        s_arr.push_back(base + amp / 2);
        s_arr.push_back(base + amp / 4);
    endtask

    task automatic run_phase(string req, int gap, int thr, int pre, int post, int idle_pct);
        g_gap = gap; g_thr = thr; g_pre = pre; g_post = post;
        g_frm = int'($urandom_range(16'hffff));
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; rd_en = 1'b0;
        cfg_gap = GW'(gap); cfg_thr = (SW+1)'(thr); cfg_pre = GW'(pre); cfg_post = PW'(post);
        frame_num = SW'(g_frm);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        got_pk.delete(); got_pw.delete();
        build_expect();
        for (int j = 0; j < s_arr.size(); j++) begin
            while (int'($urandom_range(99)) < idle_pct) begin
                smp_valid = 1'b0; smp = SW'($urandom); @(negedge clk);
            end
            smp = SW'(s_arr[j]); sample_num = SW'(j); smp_valid = 1'b1;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R10: run reports
        chk(got_pk.size() == exp_pk.size(), {req, " R10"}, "report count", got_pk.size(), exp_pk.size());
        for (int i = 0; i < exp_pk.size() && i < got_pk.size(); i++) begin
            chk(got_pk[i] == exp_pk[i], {req, " R10"}, "peak", got_pk[i], exp_pk[i]);
            chk(got_pw[i] == exp_pw[i], {req, " R10"}, "width", got_pw[i], exp_pw[i]);
        end
        // R8: drops
        chk(int'(ovf_cnt) == exp_ovf, {req, " R8"}, "drop count", ovf_cnt, exp_ovf);
        // R4 R5 R6 R7: stored stream
        for (int i = 0; i < exp_w.size(); i++) begin
            chk(!rd_empty && rd_data === exp_w[i], {req, " R4/R5/R6"}, "fifo word", rd_data, exp_w[i]);
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        @(negedge clk);
        chk(rd_empty == 1'b1, {req, " R7"}, "no extra words", rd_empty, 1);
    endtask

    initial begin
        #950000;
        $display("FAIL watchdog expired");
        total++; bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rd_empty == 1'b1, "R1", "empty", rd_empty, 1);
        chk(pulse_valid == 1'b0, "R1", "pulse_valid", pulse_valid, 0);
        chk(ovf_cnt == '0, "R1", "ovf", ovf_cnt, 0);

        // R2: equal difference does not fire, one above does
        s_arr.delete();
        add_flat(20, 200, 0);
        s_arr.push_back(500); add_flat(20, 200, 0);
        s_arr.push_back(501); add_flat(20, 200, 0);
        run_phase("R2", 1, 300, 2, 3, 0);
        chk(got_pk.size() == 1, "R2", "single firing", got_pk.size(), 1);

        // R3: ramp fires at distance 4 but not at distance 1
        s_arr.delete();
        add_flat(30, 0, 0);
        for (int i = 1; i <= 10; i++) s_arr.push_back(30 * i);
        add_flat(40, 300, 0);
        run_phase("R3", 1, 100, 1, 2, 0);
        chk(got_pk.size() == 0, "R3", "quiet at gap 1", got_pk.size(), 0);
        run_phase("R3", 4, 100, 1, 2, 0);
        chk(got_pk.size() == 1, "R3", "fires at gap 4", got_pk.size(), 1);

        // R4: two firings close together merge into one window
        s_arr.delete();
        add_flat(30, 100, 0);
        add_pulse(1000, 100); add_flat(3, 100, 0); add_pulse(900, 100);
        add_flat(40, 100, 0);
        run_phase("R4", 2, 200, 3, 10, 0);

        // R9: long ramp exceeds the body cap
        s_arr.delete();
        add_flat(10, 100, 0);
        for (int i = 1; i <= 100; i++) s_arr.push_back(100 + 10 * i);
        add_flat(20, 100, 0);
        run_phase("R9", 1, 5, 0, 0, 0);

        // random phases with varied settings; the last ones insert idle strobes (R11)
        for (int ph = 0; ph < 4; ph++) begin
            s_arr.delete();
            add_flat(40, 100, 3);
            for (int p = 0; p < 40; p++) begin
                add_pulse(int'($urandom_range(2700)) + 300, 100);
                add_flat(int'($urandom_range(75)) + 5, 100, 3);
            end
            add_flat(80, 100, 3);
            run_phase((ph < 2) ? "R6" : "R11", int'($urandom_range(HIST - 1)) + 1,
                      int'($urandom_range(140)) + 60, int'($urandom_range(HIST)),
                      int'($urandom_range(40)), (ph < 2) ? 0 : 30);
        end

        // R8: fill the FIFO without reading so later packets are dropped
        s_arr.delete();
        add_flat(20, 100, 3);
        for (int p = 0; p < 120; p++) begin
            add_pulse(int'($urandom_range(1000)) + 2000, 100);
            add_flat(37, 100, 3);
        end
        add_flat(40, 100, 3);
        run_phase("R8", 2, 300, 8, 20, 0);
        chk(exp_ovf > 0 && int'(ovf_cnt) == exp_ovf, "R8", "drops happened", ovf_cnt, exp_ovf);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule